// File: doc/BRIEF.md
# Complementary PWM Channel with Dead Band and Brake

This block is a single output-compare channel of a motor-control timer. It drives a complementary pair of outputs for a half-bridge. A prescaled up-counter runs from zero to a reload value. A reference waveform is formed by comparing the counter against a compare value, in one of eight selectable behaviours. The main output is derived from the reference and the complementary output from its inverse. A programmable dead band delays each output's turn-on, so the two outputs are never driven active at the same time.

A repetition counter sets how many counter wraps pass between update events. Prescaler, reload and compare values written at the inputs are held in shadow registers. Those registers load only at an update event, or while reset is held. A brake input overrides the pair: both outputs fall to software-chosen idle levels and the output enable is dropped. The outputs stay idle until software pulses the enable again.

Top module: `cpwm_channel`

## Requirements
- R1: With `cnt_en` high, the counter advances by one every (prescale+1) clock cycles and returns to 0 on the step after it reaches the reload value. With `cnt_en` low, the counter and prescaler hold their values.
- R2: A wrap happens when the counter leaves the reload value. If the repetition count is 0 at a wrap, `upd_evt` is high for the one cycle after that wrap, and the count is reloaded from `rep_val`. Otherwise the count is decremented. Updates therefore fall on every (rep_val+1)-th wrap after reset.
- R3: The prescale, reload and compare values in use are copied from the inputs while `rst` is high and at update events. A change at the inputs between updates has no effect on the counter or on the outputs.
- R4: `oc_mode` encoding: 0 holds the reference; 1 sets it on a match; 2 clears it on a match; 3 toggles it on a match; 4 forces it low; 5 forces it high; 6 makes it high while counter < compare; 7 makes it high while counter >= compare. A match is the first enabled cycle on which the counter equals the compare value. The reference is registered from the counter value and resets to 0.
- R5: With enable set and no brake, `out_main` follows the reference and `out_comp` follows its inverse. Both go through the dead-band stage and then the output register, two cycles after the reference.
- R6: A leg becomes active only after its source has been active for `dead_val`+1 consecutive cycles. It drops on the first cycle its source is inactive. A source pulse shorter than that leaves the leg inactive.
- R7: While the enable is set and the brake is low, `out_main` and `out_comp` are never both high.
- R8: On the clock edge where `brake_in` is high, both outputs take `idle_main`/`idle_comp` and the enable clears. After the brake is released they stay idle until a `moe_set` pulse. Outputs resume on the second edge after that pulse.
- R9: While `rst` is high, the counter is 0, `upd_evt` is 0, the enable is clear, and the outputs sit at the idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable |
| psc_val | input | 16 | Prescale value (divide by value+1), preload |
| arr_val | input | 16 | Reload value, preload |
| cmp_val | input | 16 | Compare value, preload |
| rep_val | input | 8 | Repetition count reload value |
| oc_mode | input | 3 | Reference behaviour select |
| dead_val | input | 8 | Dead band length in clocks |
| idle_main | input | 1 | Main output level when disabled or braking |
| idle_comp | input | 1 | Complementary output level when disabled or braking |
| moe_set | input | 1 | Pulse to set the output enable |
| brake_in | input | 1 | Brake request, active high |
| cnt_q | output | 16 | Current counter value |
| upd_evt | output | 1 | One-cycle update event pulse |
| out_main | output | 1 | Main output, registered |
| out_comp | output | 1 | Complementary output, registered |

## Verification
Some properties are checked by assertions on every cycle. These are: the counter stays within the active reload value and freezes while disabled; updates coincide with a zero counter; the shadow values move only on updates; a dead-band leg is active only when its source was active a cycle earlier; the pair never overlaps while enabled; and a brake forces the idle levels and drops the enable. The remaining behaviour can only be shown by the bench's scenarios. This covers the exact cycle of each counter step and wrap, the waveform of each of the eight modes, the spacing of updates over repeated wraps, the moment new reload and compare values take hold, the suppression of short pulses, and the return of the outputs after the enable is set again.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // Reference behaviour select; the numeric codes are part of the interface.
  typedef enum logic [2:0] {
    OC_FROZEN       = 3'd0,
    OC_SET_ON_MATCH = 3'd1,
    OC_CLR_ON_MATCH = 3'd2,
    OC_TOGGLE       = 3'd3,
    OC_FORCE_LO     = 3'd4,
    OC_FORCE_HI     = 3'd5,
    OC_PWM_A        = 3'd6,
    OC_PWM_B        = 3'd7
  } oc_mode_e;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] psc_val,
  input  logic [CNT_W-1:0] arr_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [REP_W-1:0] rep_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             psc_first,
  output logic [CNT_W-1:0] cmp_act,
  output logic             upd_q
);
  logic [CNT_W-1:0] psc_cnt, psc_act, arr_act;
  logic [REP_W-1:0] rep_q;
  logic tick, wrap, upd_now;

  assign tick      = cnt_en && (psc_cnt == psc_act);
  assign wrap      = tick && (cnt_q == arr_act);
  assign upd_now   = wrap && (rep_q == '0);
  assign psc_first = (psc_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_cnt <= '0;
      cnt_q   <= '0;
      rep_q   <= rep_val;
      psc_act <= psc_val;
      arr_act <= arr_val;
      cmp_act <= cmp_val;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= upd_now;
      if (tick)        psc_cnt <= '0;
      else if (cnt_en) psc_cnt <= psc_cnt + CNT_W'(1);
      if (wrap)        cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + CNT_W'(1);
      if (wrap) begin
        if (rep_q == '0) rep_q <= rep_val;
        else             rep_q <= rep_q - REP_W'(1);
      end
      if (upd_now) begin
        psc_act <= psc_val;
        arr_act <= arr_val;
        cmp_act <= cmp_val;
      end
    end
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= arr_act);
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt_q));
  // R2
  upd_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> (cnt_q == '0));
  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_q && !$past(rst)) |-> $stable({psc_act, arr_act, cmp_act}));
endmodule

// File: rtl/cpwm_refgen.sv
module cpwm_refgen
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  oc_mode_e         mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             first,
  output logic             ref_q
);
  logic hit, below;

  // A match counts once per counter value: on its first enabled cycle.
  assign hit   = cnt_en && first && (cnt == cmp);
  assign below = (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
    end else begin
      case (mode)
        OC_FROZEN:       ref_q <= ref_q;
        OC_SET_ON_MATCH: ref_q <= hit ? 1'b1 : ref_q;
        OC_CLR_ON_MATCH: ref_q <= hit ? 1'b0 : ref_q;
        OC_TOGGLE:       ref_q <= hit ? ~ref_q : ref_q;
        OC_FORCE_LO:     ref_q <= 1'b0;
        OC_FORCE_HI:     ref_q <= 1'b1;
        OC_PWM_A:        ref_q <= below;
        OC_PWM_B:        ref_q <= ~below;
      endcase
    end
  end

  // R4
  force_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OC_FORCE_HI) |=> ref_q);
  // R4
  pwm_a_low_count_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OC_PWM_A && cnt < cmp) |=> ref_q);
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src,
  input  logic [DT_W-1:0] dead,
  output logic            dt_q
);
  logic [DT_W-1:0] run_cnt;

  // Turn-on waits until the source has stayed high for dead+1 cycles;
  // turn-off follows the source at once.
  always_ff @(posedge clk) begin
    if (rst || !src) begin
      run_cnt <= '0;
      dt_q    <= 1'b0;
    end else if (run_cnt == dead) begin
      dt_q    <= 1'b1;
    end else begin
      run_cnt <= run_cnt + DT_W'(1);
    end
  end

  // R6
  leg_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    dt_q |-> $past(src));
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] psc_val,
  input  logic [CNT_W-1:0] arr_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [REP_W-1:0] rep_val,
  input  logic [2:0]       oc_mode,
  input  logic [DT_W-1:0]  dead_val,
  input  logic             idle_main,
  input  logic             idle_comp,
  input  logic             moe_set,
  input  logic             brake_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             upd_evt,
  output logic             out_main,
  output logic             out_comp
);
  localparam int LEGS = 2;

  logic [CNT_W-1:0] cmp_act;
  logic             psc_first, ref_q, moe_q;
  logic [LEGS-1:0]  leg_src, leg_dt;
  oc_mode_e         mode_e;

  assign mode_e = oc_mode_e'(oc_mode);

  cpwm_timebase #(.CNT_W(CNT_W), .REP_W(REP_W)) u_tb (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .psc_val(psc_val), .arr_val(arr_val), .cmp_val(cmp_val), .rep_val(rep_val),
    .cnt_q(cnt_q), .psc_first(psc_first), .cmp_act(cmp_act), .upd_q(upd_evt)
  );

  cpwm_refgen #(.CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode(mode_e),
    .cnt(cnt_q), .cmp(cmp_act), .first(psc_first), .ref_q(ref_q)
  );

  // Leg 0 is driven by the reference, leg 1 by its inverse.
  assign leg_src = {~ref_q, ref_q};

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    cpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst(rst), .src(leg_src[g]), .dead(dead_val), .dt_q(leg_dt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      moe_q    <= 1'b0;
      out_main <= idle_main;
      out_comp <= idle_comp;
    end else begin
      if (brake_in)     moe_q <= 1'b0;
      else if (moe_set) moe_q <= 1'b1;
      if (brake_in || !moe_q) begin
        out_main <= idle_main;
        out_comp <= idle_comp;
      end else begin
        out_main <= leg_dt[0];
        out_comp <= leg_dt[1];
      end
    end
  end

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(moe_q && !brake_in) |-> !(out_main && out_comp));
  // R8
  brake_idle_chk: assert property (@(posedge clk) disable iff (rst)
    brake_in |=> (!moe_q && out_main == $past(idle_main) && out_comp == $past(idle_comp)));
endmodule

// File: tb/cpwm_channel_tb.sv
module cpwm_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic [15:0] psc_val = '0, arr_val = 16'd4, cmp_val = '0;
  logic [7:0]  rep_val = '0, dead_val = '0;
  logic [2:0]  oc_mode = '0;
  logic        idle_main = 1'b0, idle_comp = 1'b0, moe_set = 1'b0, brake_in = 1'b0;
  logic [15:0] cnt_q;
  logic        upd_evt, out_main, out_comp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cpwm_channel dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .psc_val(psc_val), .arr_val(arr_val),
    .cmp_val(cmp_val), .rep_val(rep_val), .oc_mode(oc_mode), .dead_val(dead_val),
    .idle_main(idle_main), .idle_comp(idle_comp), .moe_set(moe_set), .brake_in(brake_in),
    .cnt_q(cnt_q), .upd_evt(upd_evt), .out_main(out_main), .out_comp(out_comp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Load a configuration and hold reset; checks the reset state (R9).
  task automatic start(input int m, input int a, input int p, input int c,
                       input int d, input int r, input bit im, input bit ic);
    @(negedge clk);
    rst = 1'b1; oc_mode = 3'(m); arr_val = 16'(a); psc_val = 16'(p);
    cmp_val = 16'(c); dead_val = 8'(d); rep_val = 8'(r);
    idle_main = im; idle_comp = ic; cnt_en = 1'b1; moe_set = 1'b1; brake_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset cnt", cnt_q, 0);
    chk("R9 reset upd", upd_evt, 0);
    chk("R9 reset out_main", out_main, im);
    chk("R9 reset out_comp", out_comp, ic);
    rst = 1'b0;
  endtask

  // Full-mode sweep with a stream model built from the requirements.
  task automatic sweep_run(input int m, input int c, input int p, input int d);
    int a = 4;
    int r = 1;
    int n = 3 * (a + 1) * (p + 1) + 4;
    int ref_p = 0, runm_p = 0, runc_p = 1, dtm_p = 0, dtc_p = 0, cnt_p = 0;
    start(m, a, p, c, d, r, 1'b0, 1'b0);
    for (int e = 1; e <= n; e++) begin
      int cnt_e, ref_e, dtm_e, dtc_e, om, oc, upd_e;
      bit first, hit, wrap;
      @(posedge clk); @(negedge clk);
      moe_set = 1'b0;
      cnt_e = (e / (p + 1)) % (a + 1);
      first = ((e - 1) % (p + 1)) == 0;
      hit   = (cnt_p == c) && first;
      case (m)
        0: ref_e = ref_p;
        1: ref_e = hit ? 1 : ref_p;
        2: ref_e = hit ? 0 : ref_p;
        3: ref_e = hit ? 1 - ref_p : ref_p;
        4: ref_e = 0;
        5: ref_e = 1;
        6: ref_e = (cnt_p < c) ? 1 : 0;
        default: ref_e = (cnt_p < c) ? 0 : 1;
      endcase
      dtm_e = (runm_p >= d + 1) ? 1 : 0;
      dtc_e = (runc_p >= d + 1) ? 1 : 0;
      om = (e >= 2) ? dtm_p : 0;
      oc = (e >= 2) ? dtc_p : 0;
      wrap  = (e % (p + 1) == 0) && ((e / (p + 1)) % (a + 1) == 0);
      upd_e = (wrap && ((e / ((p + 1) * (a + 1))) % (r + 1) == 0)) ? 1 : 0;
      chk("R1 counter", cnt_q, cnt_e);
      chk("R2 update pulse", upd_evt, upd_e);
      chk("R4 R5 R6 out_main", out_main, om);
      chk("R4 R5 R6 out_comp", out_comp, oc);
      chk("R7 overlap", (out_main && out_comp) ? 1 : 0, 0);
      runm_p = ref_e ? runm_p + 1 : 0;
      runc_p = ref_e ? 0 : runc_p + 1;
      ref_p = ref_e; dtm_p = dtm_e; dtc_p = dtc_e; cnt_p = cnt_e;
    end
  endtask

  initial begin
    // Sweep of every mode over compare, prescale and dead band corners.
    for (int m = 0; m < 8; m++)
      for (int ci = 0; ci < 4; ci++)
        for (int p = 0; p < 2; p++)
          for (int d = 0; d < 4; d += 2)
            sweep_run(m, (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? 3 : 5, p, d);

    // R6: a one-cycle reference pulse with a two-cycle dead band never reaches out_main.
    begin
      int hi = 0;
      start(6, 4, 0, 1, 2, 0, 1'b0, 1'b0);
      for (int e = 1; e <= 20; e++) begin
        @(posedge clk); @(negedge clk); moe_set = 1'b0;
        if (out_main) hi++;
      end
      chk("R6 short pulse suppressed", hi, 0);
    end

    // R3: preload values change between updates and take hold only at the update.
    start(6, 3, 0, 1, 0, 1, 1'b0, 1'b0);
    for (int e = 1; e <= 17; e++) begin
      @(posedge clk); @(negedge clk); moe_set = 1'b0;
      if (e == 1) begin arr_val = 16'd6; cmp_val = 16'd3; end
      if (e == 4)  begin chk("R3 old reload kept", cnt_q, 0); chk("R2 no update first wrap", upd_evt, 0); end
      if (e == 8)  begin chk("R3 wrap at old reload", cnt_q, 0); chk("R2 update second wrap", upd_evt, 1);
                         chk("R3 old compare kept", out_main, 0); end
      if (e == 12) chk("R3 new reload counting", cnt_q, 4);
      if (e == 13) chk("R3 new compare applied", out_main, 1);
      if (e == 14) chk("R3 reaches new reload", cnt_q, 6);
      if (e == 15) begin chk("R3 wrap at new reload", cnt_q, 0); chk("R2 no update odd wrap", upd_evt, 0); end
    end
    // R1: counter holds while disabled, resumes when enabled.
    cnt_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 hold while disabled", cnt_q, 2);
    cnt_en = 1'b1;
    @(negedge clk);
    chk("R1 resume after enable", cnt_q, 3);

    // R8: brake forces idle levels, enable stays cleared until set again.
    start(6, 4, 0, 2, 0, 0, 1'b1, 1'b0);
    repeat (8) @(negedge clk);
    moe_set = 1'b0;
    brake_in = 1'b1;
    @(negedge clk);
    chk("R8 brake main idle", out_main, 1);
    chk("R8 brake comp idle", out_comp, 0);
    @(negedge clk);
    brake_in = 1'b0;
    for (int e = 0; e < 3; e++) begin
      @(negedge clk);
      chk("R8 idle after release main", out_main, 1);
      chk("R8 idle after release comp", out_comp, 0);
    end
    moe_set = 1'b1;
    @(negedge clk);
    moe_set = 1'b0;
    begin
      int comp_hi = 0, main_lo = 0;
      for (int e = 0; e < 6; e++) begin
        @(negedge clk);
        if (out_comp) comp_hi++;
        if (!out_main) main_lo++;
      end
      chk("R8 resume comp active", (comp_hi > 0) ? 1 : 0, 1);
      chk("R8 resume main leaves idle", (main_lo > 0) ? 1 : 0, 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule